// File: doc/BRIEF.md
# Shared-Bus Status Display Arbiter

This block refreshes a bank of external display latches with per-port activity status. It does this by itself, with no processor involvement, over a narrow shared bus: a 4-bit address and a 4-bit data path. The display refresh is the default owner of the bus. It walks the ports in ascending order at a slow, prescaled rate. For each port it places the port's status nibble on the bus and pulses a latch strobe, so that plain latch logic can drive the LEDs.

A processor shares the same bus to reach a small register file. When the processor raises a request, the arbiter lets any display word in progress finish. It then grants the bus ahead of the next display word. During the grant it enables the external data buffer and points that buffer toward the block (for a write) or toward the processor (for a read). On a read, the block drives data only after one turnaround cycle with the buffer direction already set.

When a port's activity ends, the last captured indicator nibble stays frozen for a bounded number of prescaler ticks. The hold ends early if new activity starts. A separate strobe marks display words that carry a frozen value, so that external logic can latch those indicators. The tick length, the word spacing and the freeze length are parameters. The defaults give a 1 ms tick at 50 MHz, a 30 ms hold and a 1.6 s pass over 8 ports.

Top module: `statusDisplayArbiter`

## Requirements
- R1: While reset is asserted, and right after it, bufEn, busDoe, latchStb, frozenStb and cpuAck are all 0.
- R2: Display words visit port addresses in ascending order and wrap from NUM_PORTS-1 to 0. Each word has two cycles: a setup cycle with busDoe=1, then a strobe cycle with busDoe=1 and a one-cycle latchStb. In both cycles busAddr holds the port index and busDout holds that port's display nibble.
- R3: bufEn is 0 during display words and outside processor accesses; the display owns the bus by default.
- R4: On a processor write (cpuWr=1), bufEn is 1 and bufDirRead is 0 for the whole grant, and busDoe stays 0. cpuAck pulses for one cycle in the second grant cycle. At that cycle's end, busDin is stored at register address cpuAddr.
- R5: On a processor read (cpuWr=0), bufDirRead is 1 for the whole grant and busAddr equals cpuAddr. In the first grant cycle busDoe is 0. In the second, busDoe is 1, cpuAck is 1 and busDout holds the register at cpuAddr, which is the last value written there (0 after reset).
- R6: A request raised in the setup cycle of a display word lets that word's strobe complete. bufEn then rises within 3 cycles of the request, before any further display word starts.
- R7: While portActive of a port is 1, the display nibble of that port is its live portStatus nibble, and frozenStb stays 0 for its words.
- R8: When portActive falls, the nibble captured in the last active cycle is displayed for FREEZE_TICKS prescaler ticks, with frozenStb pulsing alongside each such word's latchStb. After that, the port displays 0 with no frozenStb.
- R9: New activity during a freeze ends the freeze at once: the live nibble is displayed. When that activity ends, a fresh freeze starts with the newer nibble.
- R10: frozenStb is 1 only in a latchStb cycle whose port is frozen and inactive. A port that was never active displays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portActive | input | NUM_PORTS | Per-port activity indicator |
| portStatus | input | 4*NUM_PORTS | Per-port status nibble, port p at bits [4p+3:4p] |
| cpuReq | input | 1 | Processor request, held until cpuAck is seen |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 4 | Register address of the processor access |
| busDin | input | 4 | Data arriving through the buffer on a write |
| cpuAck | output | 1 | One-cycle completion pulse |
| bufEn | output | 1 | External data buffer enable |
| bufDirRead | output | 1 | Buffer direction, 1 = toward processor |
| busAddr | output | 4 | Shared address bus (port index or cpuAddr) |
| busDout | output | 4 | Data driven by the block |
| busDoe | output | 1 | Block data drive enable |
| latchStb | output | 1 | Display latch strobe |
| frozenStb | output | 1 | Marks a latched word carrying a frozen value |

## Verification
The bench raises a processor request in the exact setup cycle of a display word. A design that preempts a word would leave a latch half-written. A design that lets the next word go ahead would show a longer grant latency. Reads are checked for the turnaround cycle: a block that drives data in the same cycle it turns the buffer would fight the processor bus. The freeze tests sample a port well inside and well past the hold window. They also restart activity mid-freeze, which exposes a design that never expires the hold, shows the post-activity nibble, or keeps a stale frozen value over live data.

// File: rtl/sda_pkg.sv
package sda_pkg;
  localparam int DATA_W = 4;
  localparam int ADDR_W = 4;
  localparam int REG_COUNT = 1 << ADDR_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_TURN,
    ST_XFER,
    ST_REL
  } ctlState_t;

  typedef struct packed {
    logic wordStrobe;
    logic cpuPhase;
    logic cpuWrite;
    logic cpuDrive;
  } dpCtrl_t;
endpackage

// File: rtl/sdaTickGen.sv
module sdaTickGen #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [CW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divCnt == CW'(TICK_DIV - 1)) begin
      divCnt <= '0;
      tick   <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      tick   <= 1'b0;
    end
  end
endmodule

// File: rtl/sdaControl.sv
module sdaControl
  import sda_pkg::*;
#(
  parameter int WORD_TICKS = 200
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    cpuReq,
  input  logic    cpuWr,
  output dpCtrl_t dpCtrl,
  output logic    bufEn,
  output logic    bufDirRead,
  output logic    busDoe,
  output logic    latchStb,
  output logic    cpuAck
);
  localparam int WCW = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1;

  ctlState_t state, nextState;
  logic [WCW-1:0] wordCnt;
  logic wordPending;
  logic dirRead;
  logic startWord, grantNow;

  assign startWord = (state == ST_IDLE) && (nextState == ST_SETUP);
  assign grantNow  = (state == ST_IDLE) && (nextState == ST_TURN);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq)           nextState = ST_TURN;
        else if (wordPending) nextState = ST_SETUP;
      end
      ST_SETUP:  nextState = ST_STROBE;
      ST_STROBE: nextState = ST_IDLE;
      ST_TURN:   nextState = ST_XFER;
      ST_XFER:   nextState = ST_REL;
      ST_REL:    if (!cpuReq) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wordCnt     <= '0;
      wordPending <= 1'b0;
      dirRead     <= 1'b0;
    end else begin
      state <= nextState;
      if (grantNow) dirRead <= !cpuWr;
      if (startWord) wordPending <= 1'b0;
      if (tick) begin
        if (wordCnt == WCW'(WORD_TICKS - 1)) begin
          wordCnt     <= '0;
          wordPending <= 1'b1;
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    dpCtrl   = '0;
    bufEn    = 1'b0;
    busDoe   = 1'b0;
    latchStb = 1'b0;
    cpuAck   = 1'b0;
    unique case (state)
      ST_SETUP: busDoe = 1'b1;
      ST_STROBE: begin
        busDoe            = 1'b1;
        latchStb          = 1'b1;
        dpCtrl.wordStrobe = 1'b1;
      end
      ST_TURN, ST_REL: begin
        bufEn           = 1'b1;
        dpCtrl.cpuPhase = 1'b1;
      end
      ST_XFER: begin
        bufEn           = 1'b1;
        cpuAck          = 1'b1;
        dpCtrl.cpuPhase = 1'b1;
        dpCtrl.cpuWrite = !dirRead;
        dpCtrl.cpuDrive = dirRead;
        busDoe          = dirRead;
      end
      default: ;
    endcase
  end

  assign bufDirRead = bufEn & dirRead;
endmodule

// File: rtl/sdaDatapath.sv
module sdaDatapath
  import sda_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int FREEZE_TICKS = 30
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  dpCtrl_t                     dpCtrl,
  input  logic [NUM_PORTS-1:0]        portActive,
  input  logic [DATA_W*NUM_PORTS-1:0] portStatus,
  input  logic [ADDR_W-1:0]           cpuAddr,
  input  logic [DATA_W-1:0]           busDin,
  output logic [ADDR_W-1:0]           busAddr,
  output logic [DATA_W-1:0]           busDout,
  output logic                        frozenStb
);
  localparam int PW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int FCW = (FREEZE_TICKS > 1) ? $clog2(FREEZE_TICKS) : 1;

  logic [DATA_W-1:0] nibbleArr [NUM_PORTS];
  logic [NUM_PORTS-1:0] frozenVec;
  logic [PW-1:0] portPtr;
  logic [DATA_W-1:0] regFile [REG_COUNT];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    logic [DATA_W-1:0] heldNib;
    logic              isFrozen;
    logic              wasActive;
    logic [FCW-1:0]    freezeCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        heldNib   <= '0;
        isFrozen  <= 1'b0;
        wasActive <= 1'b0;
        freezeCnt <= '0;
      end else if (portActive[g]) begin
        heldNib   <= portStatus[g*DATA_W +: DATA_W];
        isFrozen  <= 1'b0;
        wasActive <= 1'b1;
        freezeCnt <= '0;
      end else if (wasActive) begin
        isFrozen  <= 1'b1;
        wasActive <= 1'b0;
        freezeCnt <= '0;
      end else if (isFrozen && tick) begin
        if (freezeCnt == FCW'(FREEZE_TICKS - 1)) begin
          isFrozen <= 1'b0;
          heldNib  <= '0;
        end else begin
          freezeCnt <= freezeCnt + 1'b1;
        end
      end
    end

    assign frozenVec[g] = isFrozen & !portActive[g];
    assign nibbleArr[g] = portActive[g] ? portStatus[g*DATA_W +: DATA_W]
                        : (isFrozen ? heldNib : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portPtr <= '0;
    end else if (dpCtrl.wordStrobe) begin
      if (portPtr == PW'(NUM_PORTS - 1)) portPtr <= '0;
      else                               portPtr <= portPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (dpCtrl.cpuWrite) begin
      regFile[cpuAddr] <= busDin;
    end
  end

  assign busAddr   = dpCtrl.cpuPhase ? cpuAddr : ADDR_W'(portPtr);
  assign busDout   = dpCtrl.cpuDrive ? regFile[cpuAddr] : nibbleArr[portPtr];
  assign frozenStb = dpCtrl.wordStrobe & frozenVec[portPtr];
endmodule

// File: rtl/statusDisplayArbiter.sv
module statusDisplayArbiter
  import sda_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int TICK_DIV     = 50000,
  parameter int FREEZE_TICKS = 30,
  parameter int WORD_TICKS   = 200
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PORTS-1:0]   portActive,
  input  logic [4*NUM_PORTS-1:0] portStatus,
  input  logic                   cpuReq,
  input  logic                   cpuWr,
  input  logic [3:0]             cpuAddr,
  input  logic [3:0]             busDin,
  output logic                   cpuAck,
  output logic                   bufEn,
  output logic                   bufDirRead,
  output logic [3:0]             busAddr,
  output logic [3:0]             busDout,
  output logic                   busDoe,
  output logic                   latchStb,
  output logic                   frozenStb
);
  logic    tick;
  dpCtrl_t dpCtrl;

  sdaTickGen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  sdaControl #(.WORD_TICKS(WORD_TICKS)) ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cpuReq(cpuReq), .cpuWr(cpuWr),
    .dpCtrl(dpCtrl), .bufEn(bufEn), .bufDirRead(bufDirRead),
    .busDoe(busDoe), .latchStb(latchStb), .cpuAck(cpuAck)
  );

  sdaDatapath #(.NUM_PORTS(NUM_PORTS), .FREEZE_TICKS(FREEZE_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .dpCtrl(dpCtrl),
    .portActive(portActive), .portStatus(portStatus),
    .cpuAddr(cpuAddr), .busDin(busDin),
    .busAddr(busAddr), .busDout(busDout), .frozenStb(frozenStb)
  );
endmodule

// File: rtl/statusDisplayArbiter_chk.sv
module statusDisplayArbiter_chk (
  input logic clk,
  input logic rstN,
  input logic cpuReq,
  input logic cpuAck,
  input logic bufEn,
  input logic bufDirRead,
  input logic busDoe,
  input logic latchStb,
  input logic frozenStb
);
  logic [1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitCnt <= '0;
    else if (cpuReq && !bufEn)  waitCnt <= (waitCnt == 2'd3) ? waitCnt : waitCnt + 1'b1;
    else                        waitCnt <= '0;
  end

  p_strobe_setup_r2: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |-> (busDoe && $past(busDoe) && !bufEn));

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |=> !latchStb);

  p_no_word_in_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    bufEn |-> !latchStb);

  p_no_drive_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && !bufDirRead) |-> !busDoe);

  p_ack_in_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> bufEn);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEn) |-> !busDoe);

  p_dir_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && $past(bufEn)) |-> $stable(bufDirRead));

  p_grant_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !bufEn) |-> (waitCnt < 2'd3));

  p_frozen_with_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    frozenStb |-> latchStb);
endmodule

bind statusDisplayArbiter statusDisplayArbiter_chk chk_i (.*);

// File: tb/statusDisplayArbiter_tb_top.sv
`timescale 1ns/1ps
module statusDisplayArbiter_tb_top;
  localparam int NP = 4;
  localparam int FT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]   portActive = '0;
  logic [4*NP-1:0] portStatus = '0;
  logic cpuReq = 1'b0, cpuWr = 1'b0;
  logic [3:0] cpuAddr = '0, busDin = '0;
  logic cpuAck, bufEn, bufDirRead, busDoe, latchStb, frozenStb;
  logic [3:0] busAddr, busDout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  statusDisplayArbiter #(.NUM_PORTS(NP), .TICK_DIV(4), .FREEZE_TICKS(FT), .WORD_TICKS(2)) dut_i (
    .clk(clk), .rstN(rstN), .portActive(portActive), .portStatus(portStatus),
    .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .busDin(busDin),
    .cpuAck(cpuAck), .bufEn(bufEn), .bufDirRead(bufDirRead),
    .busAddr(busAddr), .busDout(busDout), .busDoe(busDoe),
    .latchStb(latchStb), .frozenStb(frozenStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitWord(input int port, output logic [3:0] data, output logic frz);
    bit seen = 0;
    data = '0; frz = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (latchStb && busAddr == 4'(port)) begin
        seen = 1; data = busDout; frz = frozenStb;
      end
    end
    check(seen, "R2 word for port seen", 0, 1);
  endtask

  task automatic setPort(input int p, input logic act, input logic [3:0] st);
    portActive[p] = act;
    portStatus[p*4 +: 4] = st;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!bufEn && !busDoe && !latchStb && !frozenStb && !cpuAck, "R1 reset outputs",
          {bufEn, busDoe, latchStb, frozenStb, cpuAck}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!bufEn && !busDoe && !cpuAck, "R1 after release", {bufEn, busDoe, cpuAck}, 0);
  endtask

  task automatic testScanOrder();
    logic prevDoe = 1'b0;
    int prevAddr = -1;
    int words = 0;
    bit orderOk = 1, setupOk = 1, busOk = 1;
    for (int i = 0; i < 400 && words < 2*NP + 1; i++) begin
      @(negedge clk);
      if (bufEn) busOk = 0;
      if (latchStb) begin
        if (!(prevDoe && busDoe)) setupOk = 0;
        if (prevAddr >= 0 && int'(busAddr) != (prevAddr + 1) % NP) orderOk = 0;
        prevAddr = int'(busAddr);
        words++;
      end
      prevDoe = busDoe;
    end
    check(words == 2*NP + 1, "R2 word count", words, 2*NP + 1);
    check(orderOk, "R2 ascending wrap order", orderOk, 1);
    check(setupOk, "R2 setup cycle with busDoe", setupOk, 1);
    check(busOk, "R3 no bufEn while idle", busOk, 1);
  endtask

  task automatic cpuAccess(input logic wr, input logic [3:0] addr, input logic [3:0] wdata,
                           input logic [3:0] expRead);
    bit granted = 0;
    cpuReq = 1'b1; cpuWr = wr; cpuAddr = addr; busDin = wdata;
    for (int i = 0; i < 20 && !granted; i++) begin
      @(negedge clk);
      if (bufEn) granted = 1;
    end
    check(granted, "R3 grant reached", granted, 1);
    if (wr) begin
      check(!bufDirRead && !busDoe && !cpuAck, "R4 write first cycle",
            {bufDirRead, busDoe, cpuAck}, 0);
      @(negedge clk);
      check(cpuAck && !busDoe && !bufDirRead && bufEn, "R4 write ack cycle",
            {cpuAck, busDoe, bufDirRead, bufEn}, 4'b1001);
    end else begin
      check(bufDirRead && !busDoe && !cpuAck && busAddr == addr, "R5 read turnaround",
            {bufDirRead, busDoe, cpuAck}, 3'b100);
      @(negedge clk);
      check(cpuAck && busDoe && bufDirRead, "R5 read drive cycle",
            {cpuAck, busDoe, bufDirRead}, 3'b111);
      check(busDout == expRead, "R5 read data", busDout, expRead);
    end
    cpuReq = 1'b0;
    for (int i = 0; i < 5 && bufEn; i++) @(negedge clk);
    check(!bufEn, "R3 bus returned to display", bufEn, 0);
  endtask

  task automatic testCpu();
    logic [3:0] d;
    cpuAccess(1'b0, 4'd7, 4'h0, 4'h0);
    cpuAccess(1'b1, 4'd0, 4'h9, 4'h0);
    cpuAccess(1'b1, 4'd15, 4'h6, 4'h0);
    cpuAccess(1'b1, 4'd5, 4'h3, 4'h0);
    cpuAccess(1'b1, 4'd5, 4'hE, 4'h0);
    cpuAccess(1'b0, 4'd0, 4'h0, 4'h9);
    cpuAccess(1'b0, 4'd15, 4'h0, 4'h6);
    cpuAccess(1'b0, 4'd5, 4'h0, 4'hE);
    d = 4'h0;
  endtask

  task automatic testPreempt();
    bit found = 0, sawStb = 0, lateWord = 0;
    int lat = 0;
    for (int i = 0; i < 100 && !found; i++) begin
      @(negedge clk);
      if (busDoe && !latchStb && !bufEn) found = 1;
    end
    check(found, "R6 setup cycle found", found, 1);
    cpuReq = 1'b1; cpuWr = 1'b1; cpuAddr = 4'd2; busDin = 4'hB;
    for (int i = 0; i < 10 && !bufEn; i++) begin
      @(negedge clk);
      lat++;
      if (latchStb) begin
        if (sawStb) lateWord = 1;
        sawStb = 1;
      end
    end
    check(sawStb && !lateWord, "R6 word finished before grant", {sawStb, lateWord}, 2'b10);
    check(lat == 3, "R6 grant latency", lat, 3);
    @(negedge clk);
    cpuReq = 1'b0;
    for (int i = 0; i < 5 && bufEn; i++) @(negedge clk);
    cpuAccess(1'b0, 4'd2, 4'h0, 4'hB);
  endtask

  task automatic testActivity();
    logic [3:0] d;
    logic f;
    waitWord(3, d, f);
    check(d == 4'h0 && !f, "R10 idle port shows 0", {f, d}, 0);
    setPort(1, 1'b1, 4'hA);
    setPort(0, 1'b1, 4'h7);
    waitWord(1, d, f);
    check(d == 4'hA && !f, "R7 live nibble", {f, d}, 5'h0A);
    waitWord(0, d, f);
    check(d == 4'h7 && !f, "R7 live nibble port 0, no frozenStb", {f, d}, 5'h07);
    @(negedge clk);
    setPort(1, 1'b0, 4'h3);
    repeat (60) @(negedge clk);
    waitWord(1, d, f);
    check(d == 4'hA, "R8 frozen nibble held", d, 4'hA);
    check(f, "R10 frozenStb on frozen word", f, 1);
    repeat (140) @(negedge clk);
    waitWord(1, d, f);
    check(d == 4'h0 && !f, "R8 freeze expired", {f, d}, 0);
  endtask

  task automatic testRestart();
    logic [3:0] d;
    logic f;
    @(negedge clk);
    setPort(2, 1'b1, 4'h5);
    repeat (3) @(negedge clk);
    setPort(2, 1'b0, 4'h1);
    repeat (20) @(negedge clk);
    setPort(2, 1'b1, 4'hC);
    waitWord(2, d, f);
    check(d == 4'hC && !f, "R9 new activity ends freeze", {f, d}, 5'h0C);
    @(negedge clk);
    setPort(2, 1'b0, 4'h2);
    repeat (10) @(negedge clk);
    waitWord(2, d, f);
    check(d == 4'hC && f, "R9 fresh freeze with newer nibble", {f, d}, 5'h1C);
  endtask

  initial begin
    fork
      begin
        testReset();
        testScanOrder();
        testCpu();
        testPreempt();
        testActivity();
        testRestart();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule